// File: doc/BRIEF.md
# Eight-bit accumulator ALU with status flags

This block is the arithmetic and logic datapath of a small accumulator-style microcontroller. Each cycle in which `en` is high, it takes the working-register operand `w_in`, a second operand `f_in` (a register-file byte or an instruction literal), a 5-bit operation code and the present carry. One clock edge later it presents the 8-bit result, a new flag vector, a mask that tells the status register which flags to write, and a skip request for the conditional-skip instructions. Multiply does not use the result path. It loads a separate high/low product register pair.

Carry follows the inverted-borrow convention: after a subtraction, C=1 means that no borrow occurred. Rotates either pass through carry or leave it alone. Multiply and the skip and compare operations leave every flag untouched. Instruction decode, register-file addressing and the program counter live outside the block.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a clock edge, `result`, `flags`, `flag_upd`, `skip`, `prod_hi` and `prod_lo` all become 0.
- R2: Outputs for an operation presented with `en`=1 appear after the next rising edge. When `en`=0 at an edge, `result`, `flags`, `flag_upd` and `skip` hold their values.
- R3: The adder operations are: op 0 gives W+F; op 1 gives W+F+C; op 2 gives F−W; op 3 gives F−W−(1−C); op 4 gives W−F; op 5 gives W−F−(1−C). They update all five flags (mask 0x1F). C is the carry out of bit 7, so it is 1 when a subtraction does not borrow. DC is the carry out of bit 3. OV is signed two's-complement overflow.
- R4: Z in `flags` is 1 exactly when `result` is 0, and N equals `result[7]`. The flag bit positions are C=0, DC=1, Z=2, OV=3, N=4.
- R5: The byte operations are: op 9 AND, op 10 OR, op 11 XOR, op 12 gives ~F, and op 13 passes F. Each writes Z and N (mask 0x14). Op 14 swaps the nibbles of F, and op 16 gives 0xFF; both have mask 0. Op 15 gives 0x00 with mask 0x04.
- R6: Op 17 rotates F right through carry and op 18 rotates it left through carry. Each loads C from the bit shifted out and has mask 0x15. Op 19 rotates F right and op 20 rotates it left without carry, with mask 0x14.
- R7: Op 6 gives 0−F, op 7 gives F+1 and op 8 gives F−1. Their flags follow the R3 rules with mask 0x1F.
- R8: Op 21 loads {`prod_hi`,`prod_lo`} with the unsigned product W×F, gives mask 0 and no skip. The product pair holds through every other cycle.
- R9: Each skip operation gives `skip` as follows. Op 22 gives F−1 and skips on zero, and op 23 gives F−1 and skips on non-zero. Op 24 gives F+1 and skips on zero, and op 25 gives F+1 and skips on non-zero. Ops 26, 27 and 28 give F and skip when F=W, F>W or F<W (unsigned). Op 29 gives F and skips when F=0. All have mask 0. Operations outside ops 22 to 29 never skip.
- R10: When `flag_upd[0]` is 0, `flags[0]` equals the `c_in` that was presented with the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Execute the presented operation this cycle |
| op_sel | input | 5 | Operation code |
| w_in | input | 8 | Working-register operand |
| f_in | input | 8 | File or literal operand |
| c_in | input | 1 | Current carry flag |
| result | output | 8 | Registered result byte |
| flags | output | 5 | Registered flags {N,OV,Z,DC,C} |
| flag_upd | output | 5 | Registered mask of flags to write back |
| skip | output | 1 | Registered skip request |
| prod_hi | output | 8 | Product high byte |
| prod_lo | output | 8 | Product low byte |

## Verification
Every result is registered. The result byte, the flags, the write mask, the skip request and the product pair are all due at the first rising edge after the operation is presented. The bench drives each operation on a falling edge and samples all outputs on the next falling edge, half a period after the single capturing edge. For the hold and product-retention cases, a further falling edge passes before the sample, so a register that moved wrongly would already have changed.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int ALU_DW = 8;
  localparam int OP_W   = 5;
  localparam int NFLAG  = 5;

  localparam int FB_C  = 0;
  localparam int FB_DC = 1;
  localparam int FB_Z  = 2;
  localparam int FB_OV = 3;
  localparam int FB_N  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'd0,
    OP_ADDC   = 5'd1,
    OP_SUB    = 5'd2,
    OP_SUBB   = 5'd3,
    OP_RSUB   = 5'd4,
    OP_RSUBB  = 5'd5,
    OP_NEG    = 5'd6,
    OP_INC    = 5'd7,
    OP_DEC    = 5'd8,
    OP_AND    = 5'd9,
    OP_IOR    = 5'd10,
    OP_XOR    = 5'd11,
    OP_COM    = 5'd12,
    OP_MOV    = 5'd13,
    OP_SWAP   = 5'd14,
    OP_CLR    = 5'd15,
    OP_SET    = 5'd16,
    OP_RRC    = 5'd17,
    OP_RLC    = 5'd18,
    OP_RRN    = 5'd19,
    OP_RLN    = 5'd20,
    OP_MUL    = 5'd21,
    OP_DECSZ  = 5'd22,
    OP_DECSNZ = 5'd23,
    OP_INCSZ  = 5'd24,
    OP_INCSNZ = 5'd25,
    OP_CPEQ   = 5'd26,
    OP_CPGT   = 5'd27,
    OP_CPLT   = 5'd28,
    OP_TSTZ   = 5'd29,
    OP_RSV0   = 5'd30,
    OP_RSV1   = 5'd31
  } alu_op_e;

  localparam logic [NFLAG-1:0] MASK_ALL  = 5'h1F;
  localparam logic [NFLAG-1:0] MASK_ZN   = 5'h14;
  localparam logic [NFLAG-1:0] MASK_ZNC  = 5'h15;
  localparam logic [NFLAG-1:0] MASK_Z    = 5'h04;
  localparam logic [NFLAG-1:0] MASK_NONE = 5'h00;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int DW = ALU_DW
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   w_val,
  input  logic [DW-1:0]   f_val,
  input  logic            c_in,
  output logic [DW-1:0]   sum,
  output logic            c_out,
  output logic            dc_out,
  output logic            ov_out
);
  localparam int HW = DW / 2;

  logic [DW-1:0] opa, opb;
  logic          cin_eff;
  logic [DW:0]   full;
  logic [HW:0]   half;

  // Subtraction is a + ~b + 1 (or + C for borrow forms), so carry out is
  // the inverted borrow.
  always_comb begin
    opa     = w_val;
    opb     = f_val;
    cin_eff = 1'b0;
    case (op)
      OP_ADD:   begin opa = w_val; opb = f_val;  cin_eff = 1'b0; end
      OP_ADDC:  begin opa = w_val; opb = f_val;  cin_eff = c_in; end
      OP_SUB:   begin opa = f_val; opb = ~w_val; cin_eff = 1'b1; end
      OP_SUBB:  begin opa = f_val; opb = ~w_val; cin_eff = c_in; end
      OP_RSUB:  begin opa = w_val; opb = ~f_val; cin_eff = 1'b1; end
      OP_RSUBB: begin opa = w_val; opb = ~f_val; cin_eff = c_in; end
      OP_NEG:   begin opa = '0;    opb = ~f_val; cin_eff = 1'b1; end
      OP_INC, OP_INCSZ, OP_INCSNZ:
                begin opa = f_val; opb = '0;     cin_eff = 1'b1; end
      OP_DEC, OP_DECSZ, OP_DECSNZ:
                begin opa = f_val; opb = '1;     cin_eff = 1'b0; end
      default:  begin opa = w_val; opb = f_val;  cin_eff = 1'b0; end
    endcase
  end

  assign full   = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin_eff};
  assign half   = {1'b0, opa[HW-1:0]} + {1'b0, opb[HW-1:0]} + {{HW{1'b0}}, cin_eff};
  assign sum    = full[DW-1:0];
  assign c_out  = full[DW];
  assign dc_out = half[HW];
  assign ov_out = (opa[DW-1] == opb[DW-1]) && (full[DW-1] != opa[DW-1]);

endmodule

// File: rtl/alu8_bytelogic.sv
module alu8_bytelogic
  import alu8_pkg::*;
#(
  parameter int DW = ALU_DW
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   w_val,
  input  logic [DW-1:0]   f_val,
  input  logic            c_in,
  output logic [DW-1:0]   res,
  output logic            rot_c
);
  localparam int HW = DW / 2;

  always_comb begin
    rot_c = c_in;
    case (op)
      OP_AND:  res = w_val & f_val;
      OP_IOR:  res = w_val | f_val;
      OP_XOR:  res = w_val ^ f_val;
      OP_COM:  res = ~f_val;
      OP_SWAP: res = {f_val[HW-1:0], f_val[DW-1:HW]};
      OP_CLR:  res = '0;
      OP_SET:  res = '1;
      OP_RRC:  begin res = {c_in, f_val[DW-1:1]};     rot_c = f_val[0];    end
      OP_RLC:  begin res = {f_val[DW-2:0], c_in};     rot_c = f_val[DW-1]; end
      OP_RRN:  res = {f_val[0], f_val[DW-1:1]};
      OP_RLN:  res = {f_val[DW-2:0], f_val[DW-1]};
      default: res = f_val;
    endcase
  end

endmodule

// File: rtl/alu8_mult.sv
module alu8_mult #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] prod_hi,
  output logic [DW-1:0] prod_lo
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod_q;

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else if (load) prod_q <= {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
  end

  assign prod_hi = prod_q[PW-1:DW];
  assign prod_lo = prod_q[DW-1:0];

  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({prod_hi, prod_lo})); // R8

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = ALU_DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [DW-1:0]    w_in,
  input  logic [DW-1:0]    f_in,
  input  logic             c_in,
  output logic [DW-1:0]    result,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] flag_upd,
  output logic             skip,
  output logic [DW-1:0]    prod_hi,
  output logic [DW-1:0]    prod_lo
);
  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  logic [DW-1:0] as_sum, lg_res;
  logic          as_c, as_dc, as_ov, lg_c;

  alu8_addsub #(.DW(DW)) u_addsub (
    .op(op), .w_val(w_in), .f_val(f_in), .c_in(c_in),
    .sum(as_sum), .c_out(as_c), .dc_out(as_dc), .ov_out(as_ov)
  );

  alu8_bytelogic #(.DW(DW)) u_logic (
    .op(op), .w_val(w_in), .f_val(f_in), .c_in(c_in),
    .res(lg_res), .rot_c(lg_c)
  );

  alu8_mult #(.DW(DW)) u_mult (
    .clk(clk), .rst(rst), .load(en && (op == OP_MUL)),
    .a(w_in), .b(f_in), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  logic [DW-1:0]    res_d;
  logic [NFLAG-1:0] mask_d, flg_d;
  logic             skip_d, use_sum;

  always_comb begin
    use_sum = 1'b0;
    res_d   = f_in;
    mask_d  = MASK_NONE;
    skip_d  = 1'b0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_RSUB, OP_RSUBB,
      OP_NEG, OP_INC, OP_DEC: begin
        use_sum = 1'b1; res_d = as_sum; mask_d = MASK_ALL;
      end
      OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV, OP_RRN, OP_RLN: begin
        res_d = lg_res; mask_d = MASK_ZN;
      end
      OP_RRC, OP_RLC: begin res_d = lg_res; mask_d = MASK_ZNC; end
      OP_CLR:         begin res_d = lg_res; mask_d = MASK_Z;   end
      OP_SWAP, OP_SET: res_d = lg_res;
      OP_DECSZ, OP_INCSZ:   begin res_d = as_sum; skip_d = (as_sum == '0); end
      OP_DECSNZ, OP_INCSNZ: begin res_d = as_sum; skip_d = (as_sum != '0); end
      OP_CPEQ: skip_d = (f_in == w_in);
      OP_CPGT: skip_d = (f_in >  w_in);
      OP_CPLT: skip_d = (f_in <  w_in);
      OP_TSTZ: skip_d = (f_in == '0);
      default: ;
    endcase
  end

  always_comb begin
    flg_d        = '0;
    flg_d[FB_C]  = mask_d[FB_C] ? (use_sum ? as_c : lg_c) : c_in;
    flg_d[FB_DC] = as_dc;
    flg_d[FB_OV] = as_ov;
    flg_d[FB_Z]  = (res_d == '0);
    flg_d[FB_N]  = res_d[DW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      flags    <= '0;
      flag_upd <= '0;
      skip     <= 1'b0;
    end else if (en) begin
      result   <= res_d;
      flags    <= flg_d;
      flag_upd <= mask_d;
      skip     <= skip_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(result) && $stable(flags) && $stable(skip)); // R2

  AST_CARRY_PASS: assert property (@(posedge clk) disable iff (rst)
    (en && !(op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_RSUB, OP_RSUBB,
                        OP_NEG, OP_INC, OP_DEC, OP_RRC, OP_RLC}))
    |=> (flags[FB_C] == $past(c_in))); // R10

  AST_ROTR_CARRY: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_RRC) |=> (flags[FB_C] == $past(f_in[0])) &&
                             (result[DW-1] == $past(c_in))); // R6

  AST_MUL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_MUL) |=> (flag_upd == '0) && !skip); // R8

  AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (en && !(op inside {OP_DECSZ, OP_DECSNZ, OP_INCSZ, OP_INCSNZ,
                        OP_CPEQ, OP_CPGT, OP_CPLT, OP_TSTZ})) |=> !skip); // R9

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  // {op[40:36], w[35:28], f[27:20], c[19], res[18:11], flags[10:6], mask[5:1], skip[0]}
  localparam logic [40:0] VEC [NV] = '{
    {5'd0,  8'h80, 8'h80, 1'b0, 8'h00, 5'b01101, 5'h1F, 1'b0},
    {5'd0,  8'h01, 8'hFF, 1'b0, 8'h00, 5'b00111, 5'h1F, 1'b0},
    {5'd1,  8'hA5, 8'h05, 1'b1, 8'hAB, 5'b10000, 5'h1F, 1'b0},
    {5'd2,  8'hAA, 8'hFF, 1'b0, 8'h55, 5'b00011, 5'h1F, 1'b0},
    {5'd3,  8'h01, 8'h00, 1'b0, 8'hFE, 5'b10000, 5'h1F, 1'b0},
    {5'd4,  8'h10, 8'h20, 1'b0, 8'hF0, 5'b10010, 5'h1F, 1'b0},
    {5'd5,  8'h80, 8'h01, 1'b1, 8'h7F, 5'b01001, 5'h1F, 1'b0},
    {5'd6,  8'h00, 8'hFF, 1'b0, 8'h01, 5'b00000, 5'h1F, 1'b0},
    {5'd7,  8'h00, 8'h7F, 1'b0, 8'h80, 5'b11010, 5'h1F, 1'b0},
    {5'd8,  8'h00, 8'h00, 1'b1, 8'hFF, 5'b10000, 5'h1F, 1'b0},
    {5'd9,  8'hA5, 8'h5A, 1'b1, 8'h00, 5'b00100, 5'h14, 1'b0},
    {5'd10, 8'h0A, 8'h50, 1'b0, 8'h5A, 5'b00000, 5'h14, 1'b0},
    {5'd11, 8'hFF, 8'h5A, 1'b1, 8'hA5, 5'b10000, 5'h14, 1'b0},
    {5'd12, 8'h00, 8'hA5, 1'b0, 8'h5A, 5'b00000, 5'h14, 1'b0},
    {5'd14, 8'h00, 8'hA5, 1'b1, 8'h5A, 5'b00000, 5'h00, 1'b0},
    {5'd15, 8'h00, 8'h33, 1'b0, 8'h00, 5'b00100, 5'h04, 1'b0},
    {5'd16, 8'h00, 8'h12, 1'b1, 8'hFF, 5'b00000, 5'h00, 1'b0},
    {5'd17, 8'h00, 8'h01, 1'b0, 8'h00, 5'b00101, 5'h15, 1'b0},
    {5'd18, 8'h00, 8'h01, 1'b0, 8'h02, 5'b00000, 5'h15, 1'b0},
    {5'd18, 8'h00, 8'h80, 1'b1, 8'h01, 5'b00001, 5'h15, 1'b0},
    {5'd19, 8'h00, 8'hA5, 1'b1, 8'hD2, 5'b10000, 5'h14, 1'b0},
    {5'd20, 8'h00, 8'hA5, 1'b0, 8'h4B, 5'b00000, 5'h14, 1'b0},
    {5'd13, 8'h00, 8'h80, 1'b0, 8'h80, 5'b10000, 5'h14, 1'b0},
    {5'd22, 8'h00, 8'h01, 1'b0, 8'h00, 5'b00000, 5'h00, 1'b1},
    {5'd23, 8'h00, 8'h01, 1'b1, 8'h00, 5'b00000, 5'h00, 1'b0},
    {5'd24, 8'h00, 8'hFF, 1'b0, 8'h00, 5'b00000, 5'h00, 1'b1},
    {5'd25, 8'h00, 8'hFF, 1'b1, 8'h00, 5'b00000, 5'h00, 1'b0},
    {5'd26, 8'h01, 8'h01, 1'b0, 8'h01, 5'b00000, 5'h00, 1'b1},
    {5'd27, 8'h00, 8'h01, 1'b1, 8'h01, 5'b00000, 5'h00, 1'b1},
    {5'd28, 8'h02, 8'h01, 1'b0, 8'h01, 5'b00000, 5'h00, 1'b1},
    {5'd28, 8'h01, 8'h02, 1'b1, 8'h02, 5'b00000, 5'h00, 1'b0},
    {5'd29, 8'h55, 8'h00, 1'b0, 8'h00, 5'b00000, 5'h00, 1'b1},
    {5'd21, 8'h0A, 8'hA0, 1'b1, 8'hA0, 5'b00000, 5'h00, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] w_in = '0, f_in = '0;
  logic       c_in = 1'b0;
  logic [7:0] result, prod_hi, prod_lo;
  logic [4:0] flags, flag_upd;
  logic       skip;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core u_alu8_core (
    .clk(clk), .rst(rst), .en(en), .op_sel(op_sel), .w_in(w_in), .f_in(f_in),
    .c_in(c_in), .result(result), .flags(flags), .flag_upd(flag_upd),
    .skip(skip), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] o, input logic [7:0] w,
                       input logic [7:0] f, input logic c);
    @(negedge clk);
    op_sel = o; w_in = w; f_in = f; c_in = c; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  function automatic string req_of(input logic [4:0] o);
    if (o <= 5'd5) return "R3";
    if (o <= 5'd8) return "R7";
    if (o <= 5'd16) return "R5";
    if (o <= 5'd20) return "R6";
    if (o == 5'd21) return "R8";
    return "R9";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset outputs", {result, flags, flag_upd, 7'b0, skip, prod_hi, prod_lo}, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      issue(v[40:36], v[35:28], v[27:20], v[19]);
      check(req_of(v[40:36]), $sformatf("result op%0d", v[40:36]), {24'b0, result}, {24'b0, v[18:11]});
      check("R10", $sformatf("mask op%0d", v[40:36]), {27'b0, flag_upd}, {27'b0, v[5:1]});
      check(req_of(v[40:36]), $sformatf("flags op%0d", v[40:36]),
            {27'b0, flags & v[5:1]}, {27'b0, v[10:6] & v[5:1]});
      check("R9", $sformatf("skip op%0d", v[40:36]), {31'b0, skip}, {31'b0, v[0]});
      check("R4", $sformatf("Z/N op%0d", v[40:36]), {30'b0, flags[4], flags[2]},
            {30'b0, v[18], (v[18:11] == 8'h00)});
      if (!v[1])
        check("R10", $sformatf("carry pass op%0d", v[40:36]), {31'b0, flags[0]}, {31'b0, v[19]});
    end

    // R8: product of last vector (0x0A * 0xA0)
    check("R8", "product 0A*A0", {16'b0, prod_hi, prod_lo}, 32'h0640);
    issue(5'd21, 8'h40, 8'h0A, 1'b0);
    check("R8", "product 40*0A", {16'b0, prod_hi, prod_lo}, 32'h0280);
    issue(5'd0, 8'h33, 8'h44, 1'b0);
    check("R8", "product kept by add", {16'b0, prod_hi, prod_lo}, 32'h0280);
    check("R3", "add 33+44", {24'b0, result}, 32'h77);

    // R2: en low holds outputs
    @(negedge clk);
    op_sel = 5'd16; w_in = 8'h00; f_in = 8'h00; c_in = 1'b1; en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2", "hold result", {24'b0, result}, 32'h77);
    check("R2", "hold mask", {27'b0, flag_upd}, 32'h1F);
    check("R8", "product kept idle", {16'b0, prod_hi, prod_lo}, 32'h0280);

    // R2: one-edge latency
    @(negedge clk);
    op_sel = 5'd11; w_in = 8'hF0; f_in = 8'h0F; c_in = 1'b0; en = 1'b1;
    @(posedge clk);
    #1;
    en = 1'b0;
    check("R2", "result after one edge", {24'b0, result}, 32'hFF);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset mid-run", {result, flags, flag_upd, 7'b0, skip, prod_hi, prod_lo}, '0);
    rst = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule